// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Sequencer

This block issues column commands to an SDRAM whose rows are already open. A requester hands it one read or write at a time over a valid/ready port. Each request carries a bank, a column and a tag. A write also carries one data word and a byte mask. Each accepted read becomes a single-word READ command. Its data is captured from the SDRAM data bus once the CAS latency has passed, and it comes back to the requester with its tag. Reads can go out on consecutive clocks, and their data returns as an unbroken stream.

A write may arrive while read data is still in flight. The block then does not wait for the stream to drain. It raises DQM on the clock before the WRITE so that the cut-off read is legal. DQM reaches the output buffers two clocks later, so it also blanks read data that would otherwise come back in that window. Once the WRITE is on the bus, the SDRAM has released the data pins, and every later read slot is dropped.

An optional turnaround mode keeps one idle bus clock between the last driven read word and the WRITE. The `cas3` input picks a CAS latency of 3 (high) or 2 (low). `cas3` and `gap_en` may only change while no read is in flight.

Top module: `sdram_colseq`

## Requirements
- R1: During reset and right after it, `sd_cmd` is NOP (2'b00), `sd_dqm` is all zeros, and `sd_dq_oe` and `rd_valid` are low.
- R2: A clock edge that accepts no request puts NOP on `sd_cmd` for the next cycle. DQM is zero unless a write is waiting (see R6).
- R3: A read is accepted on any cycle with `req_valid` high and `req_write` low. It appears in the next cycle as READ (2'b01) with its bank and column, and DQM is zero during the READ cycle.
- R4: A READ in cycle T that is neither blanked nor cut off gives `rd_valid` in cycle T+CL+1. CL is 3 when `cas3` is high and 2 when it is low. `rd_data` equals the `sd_dq_in` value from cycle T+CL, and `rd_tag` equals the request tag. Results come out in issue order.
- R5: An accepted write appears in the next cycle as WRITE (2'b10) with its bank, column, data and byte mask on `sd_dqm`. `sd_dq_oe` is high in that cycle and in no other.
- R6: If any live read slot falls in the WRITE cycle or later, DQM is all ones in the cycle right before the WRITE. While such a write waits, the block drives NOP with DQM all ones.
- R7: DQM all ones in a non-WRITE cycle t blanks the read slot of cycle t+2, and that slot produces no `rd_valid`.
- R8: A WRITE in cycle W cuts off every read slot in cycle W or later, and those slots produce no `rd_valid`.
- R9: With `gap_en` high, the SDRAM drives no read data in the cycle right before a WRITE.
- R10: `sd_dq_oe` is never high in a cycle in which the SDRAM drives read data.
- R11: `req_ready` is high for reads and idle cycles. It is low for a write that cannot issue in the next cycle, and no WRITE follows such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas3 | input | 1 | CAS latency select: 1 = 3 clocks, 0 = 2 clocks |
| gap_en | input | 1 | Keep one idle bus clock before a WRITE |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Target column |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Write byte mask, 1 = byte not written |
| req_tag | input | TAG_W | Read tag returned with the data |
| sd_cmd | output | 2 | Command: 00 NOP, 01 READ, 10 WRITE |
| sd_bank | output | BANK_W | Bank address |
| sd_col | output | COL_W | Column address |
| sd_dqm | output | DATA_W/8 | DQM pins |
| sd_dq_out | output | DATA_W | Write data to the data bus |
| sd_dq_oe | output | 1 | Controller drives the data bus |
| sd_dq_in | input | DATA_W | Data bus as seen by the controller |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Read result data |
| rd_tag | output | TAG_W | Read result tag |

## Verification
Most faults sit in the slot pipeline, which holds one live bit per pending read slot. A bit lost there shows as a missing `rd_valid` CL+1 cycles after the READ. A stale bit shows as a spurious pulse, or as a WRITE held back or issued too early at the next write. A wrong latency index moves every result by one cycle, and the next read exposes it. A wrong truncation decision shows at the first write that meets a read stream. It appears either as a WRITE without DQM high in the cycle before it, or as both sides driving the bus in the same cycle. The bench's bus model flags either one in that cycle.

// File: rtl/colseq_pkg.sv
package colseq_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10
    } cmd_e;

    localparam int LO_CL     = 2;
    localparam int HI_CL     = 3;
    localparam int PIPE_D    = HI_CL + 1;
    // DQM reaches the output buffers this many clocks later
    localparam int DQM_LAT   = 2;
endpackage

// File: rtl/colseq_slot_pipe.sv
// Tracks which future data-bus cycles carry a wanted read word.
// Index k refers to the current output cycle plus k.
module colseq_slot_pipe
    import colseq_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cas3,
    input  logic                       rd_go,
    input  logic                       blank_go,
    input  logic                       cut_go,
    input  logic [TAG_W-1:0]           tag_in,
    output logic [PIPE_D-1:0]          alive_q,
    output logic [TAG_W-1:0]           tag_now
);
    typedef struct packed {
        logic [PIPE_D-1:0]             alive;
        logic [PIPE_D-1:0][TAG_W-1:0]  tag;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        for (int k = 0; k < PIPE_D - 1; k++) begin
            p_d.alive[k] = p_q.alive[k+1];
            p_d.tag[k]   = p_q.tag[k+1];
        end
        p_d.alive[PIPE_D-1] = 1'b0;
        if (rd_go) begin
            if (cas3) begin
                p_d.alive[HI_CL] = 1'b1;
                p_d.tag[HI_CL]   = tag_in;
            end else begin
                p_d.alive[LO_CL] = 1'b1;
                p_d.tag[LO_CL]   = tag_in;
            end
        end
        if (blank_go) p_d.alive[DQM_LAT] = 1'b0;
        if (cut_go)   p_d.alive = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign alive_q = p_q.alive;
    assign tag_now = p_q.tag[0];
endmodule

// File: rtl/colseq_rd_return.sv
// Captures the data bus in a live slot and presents it with its tag.
module colseq_rd_return #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_live,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [TAG_W-1:0]  tag_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } ret_t;

    ret_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.vld = slot_live;
        if (slot_live) begin
            r_d.data = dq_in;
            r_d.tag  = tag_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid = r_q.vld;
    assign rd_data  = r_q.data;
    assign rd_tag   = r_q.tag;
endmodule

// File: rtl/sdram_colseq.sv
module sdram_colseq
    import colseq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cas3,
    input  logic                   gap_en,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [BANK_W-1:0]      req_bank,
    input  logic [COL_W-1:0]       req_col,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_mask,
    input  logic [TAG_W-1:0]       req_tag,
    output logic [1:0]             sd_cmd,
    output logic [BANK_W-1:0]      sd_bank,
    output logic [COL_W-1:0]       sd_col,
    output logic [DATA_W/8-1:0]    sd_dqm,
    output logic [DATA_W-1:0]      sd_dq_out,
    output logic                   sd_dq_oe,
    input  logic [DATA_W-1:0]      sd_dq_in,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    output logic [TAG_W-1:0]       rd_tag
);
    localparam int MASK_W = DATA_W / 8;

    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [MASK_W-1:0] dqm;
        logic [DATA_W-1:0] wdata;
        logic              oe;
    } bus_t;

    bus_t bus_d, bus_q;

    logic [PIPE_D-1:0] alive_q;
    logic [TAG_W-1:0]  tag_now;
    logic              pend_later;
    logic              wr_ok;
    logic              rd_go, wr_go, blank_go;

    always_comb begin
        // a read word still due in the next cycle or later would be cut
        pend_later = |alive_q[PIPE_D-1:1];
        wr_ok      = (!pend_later || (&bus_q.dqm))
                   && (!gap_en || !alive_q[0]);
        req_ready  = !req_write || wr_ok;

        bus_d      = bus_q;
        bus_d.cmd  = CMD_NOP;
        bus_d.dqm  = '0;
        bus_d.oe   = 1'b0;
        if (req_valid && req_ready) begin
            bus_d.bank = req_bank;
            bus_d.col  = req_col;
            if (req_write) begin
                bus_d.cmd   = CMD_WR;
                bus_d.dqm   = req_mask;
                bus_d.wdata = req_wdata;
                bus_d.oe    = 1'b1;
            end else begin
                bus_d.cmd   = CMD_RD;
            end
        end else if (req_valid && req_write) begin
            // waiting write: blank pending read words, prepare the cut
            bus_d.dqm = '1;
        end

        rd_go    = (bus_d.cmd == CMD_RD);
        wr_go    = (bus_d.cmd == CMD_WR);
        blank_go = (&bus_d.dqm) && !wr_go;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    colseq_slot_pipe #(.TAG_W(TAG_W)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cas3     (cas3),
        .rd_go    (rd_go),
        .blank_go (blank_go),
        .cut_go   (wr_go),
        .tag_in   (req_tag),
        .alive_q  (alive_q),
        .tag_now  (tag_now)
    );

    colseq_rd_return #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_live (alive_q[0]),
        .dq_in     (sd_dq_in),
        .tag_in    (tag_now),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_tag    (rd_tag)
    );

    assign sd_cmd    = bus_q.cmd;
    assign sd_bank   = bus_q.bank;
    assign sd_col    = bus_q.col;
    assign sd_dqm    = bus_q.dqm;
    assign sd_dq_out = bus_q.wdata;
    assign sd_dq_oe  = bus_q.oe;
endmodule

// File: rtl/colseq_chk.sv
module colseq_chk
    import colseq_pkg::*;
#(
    parameter int MASK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gap_en,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic [1:0]        sd_cmd,
    input logic [MASK_W-1:0] sd_dqm,
    input logic              sd_dq_oe,
    input logic              rd_valid,
    input logic [PIPE_D-1:0] alive
);
    // R5
    oe_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (sd_cmd == 2'b10));

    // R3
    read_dqm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == 2'b01) |-> (sd_dqm == '0));

    // R6
    trunc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_cmd == 2'b10) && $past(|alive[PIPE_D-1:1])) |-> $past(&sd_dqm));

    // R9
    gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_en && (sd_cmd == 2'b10)) |-> !$past(alive[0]));

    // R8
    cut_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == 2'b10) |=> !rd_valid);

    // R11
    held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_ready) |=> (sd_cmd != 2'b10));
endmodule

bind sdram_colseq colseq_chk #(.MASK_W(DATA_W/8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gap_en    (gap_en),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .sd_cmd    (sd_cmd),
    .sd_dqm    (sd_dqm),
    .sd_dq_oe  (sd_dq_oe),
    .rd_valid  (rd_valid),
    .alive     (alive_q)
);

// File: tb/sdram_colseq_test.sv
module sdram_colseq_test;
    localparam int BW = 2, CW = 9, DW = 16, MW = DW / 8, TW = 4;
    localparam int HN = 4096, QN = 1024;

    logic clk = 1'b0, rst_n = 1'b0, cas3 = 1'b0, gap_en = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [CW-1:0] req_col = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [MW-1:0] req_mask = '0;
    logic [TW-1:0] req_tag = '0;
    logic [DW-1:0] sd_dq_in = '0;
    logic          req_ready, sd_dq_oe, rd_valid;
    logic [1:0]    sd_cmd;
    logic [BW-1:0] sd_bank;
    logic [CW-1:0] sd_col;
    logic [MW-1:0] sd_dqm;
    logic [DW-1:0] sd_dq_out, rd_data;
    logic [TW-1:0] rd_tag;

    sdram_colseq #(.BANK_W(BW), .COL_W(CW), .DATA_W(DW), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .cas3(cas3), .gap_en(gap_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_col(req_col), .req_wdata(req_wdata),
        .req_mask(req_mask), .req_tag(req_tag),
        .sd_cmd(sd_cmd), .sd_bank(sd_bank), .sd_col(sd_col), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, cl = 2;
    bit done = 1'b0;

    // history: a_ = what the design drove, m_ = what the model expected
    logic [1:0]    a_cmd [HN];
    logic [1:0]    m_cmd [HN];
    bit            a_dqa [HN];
    bit            m_dqa [HN];
    logic [TW-1:0] m_tag [HN];

    // request list: kind 0 idle cycle, 1 read, 2 write
    int            q_kind [QN];
    logic [BW-1:0] q_bank [QN];
    logic [CW-1:0] q_col  [QN];
    logic [DW-1:0] q_data [QN];
    logic [MW-1:0] q_mask [QN];
    logic [TW-1:0] q_tag  [QN];
    int q_n = 0, q_head = 0;

    logic [1:0]    nx_cmd = 2'b00;
    logic [BW-1:0] nx_bank = '0;
    logic [CW-1:0] nx_col = '0;
    logic [MW-1:0] nx_dqm = '0;
    logic [DW-1:0] nx_data = '0;
    logic [TW-1:0] nx_tag = '0;
    bit            nx_oe = 1'b0;
    string         nx_lbl = "R2";
    bit            exp_ready = 1'b1;
    bit            acc_prev = 1'b0;
    logic [TW-1:0] tag_ctr = '0;

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", rq, what, cyc, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] sd_val(int s);
        return DW'(s * 613 + 41);
    endfunction

    // 0 no read slot, 1 driven and wanted, 2 blanked by DQM, 3 cut by a WRITE
    function automatic int slot_st(int s, bit act);
        int r;
        r = s - cl;
        if (r < 0 || r > cyc || s >= HN) return 0;
        if ((act ? a_cmd[r] : m_cmd[r]) != 2'b01) return 0;
        for (int w = r + 1; w <= s && w <= cyc; w++)
            if ((act ? a_cmd[w] : m_cmd[w]) == 2'b10) return 3;
        if (s - 2 >= 0 && s - 2 <= cyc && (act ? a_dqa[s-2] : m_dqa[s-2])) return 2;
        return 1;
    endfunction

    task automatic push(int kind, logic [BW-1:0] b, logic [CW-1:0] c, logic [DW-1:0] d, logic [MW-1:0] m);
        q_kind[q_n] = kind; q_bank[q_n] = b; q_col[q_n] = c;
        q_data[q_n] = d; q_mask[q_n] = m; q_tag[q_n] = tag_ctr;
        if (kind == 1) tag_ctr = tag_ctr + 1'b1;
        q_n++;
    endtask

    task automatic idles(int n);
        for (int i = 0; i < n; i++) push(0, '0, '0, '0, '0);
    endtask

    task automatic step();
        int st;
        string lbl;
        bit drv, trunc, ok, hv, hw;
        @(negedge clk);
        if (acc_prev) q_head++;
        a_cmd[cyc] = sd_cmd;  a_dqa[cyc] = &sd_dqm;
        m_cmd[cyc] = nx_cmd;  m_dqa[cyc] = &nx_dqm; m_tag[cyc] = nx_tag;

        chk(sd_cmd === nx_cmd, nx_lbl, "command", sd_cmd, nx_cmd);
        chk(sd_dqm === nx_dqm, nx_lbl, "dqm", sd_dqm, nx_dqm);
        chk(sd_dq_oe === nx_oe, "R5", "data output enable", sd_dq_oe, nx_oe);
        if (nx_cmd != 2'b00) begin
            chk(sd_bank === nx_bank, nx_lbl, "bank", sd_bank, nx_bank);
            chk(sd_col === nx_col, nx_lbl, "column", sd_col, nx_col);
        end
        if (nx_cmd == 2'b10) chk(sd_dq_out === nx_data, "R5", "write data", sd_dq_out, nx_data);

        st = (cyc >= 1) ? slot_st(cyc - 1, 1'b0) : 0;
        lbl = (st == 2) ? "R7" : (st == 3) ? "R8" : "R4";
        chk(rd_valid === (st == 1), lbl, "rd_valid", rd_valid, (st == 1));
        if (st == 1) begin
            chk(rd_data === sd_val(cyc - 1), "R4", "rd_data", rd_data, sd_val(cyc - 1));
            chk(rd_tag === m_tag[cyc-1-cl], "R4", "rd_tag", rd_tag, m_tag[cyc-1-cl]);
        end

        // data-bus model driven by the design's actual commands
        drv = (slot_st(cyc, 1'b1) == 1);
        chk(!(sd_dq_oe && drv), "R10", "bus contention", sd_dq_oe, 0);
        if (sd_cmd == 2'b10 && cyc >= 1) begin
            bit infl;
            infl = 1'b0;
            for (int s = cyc; s <= cyc + 3; s++) begin
                int r;
                bit cut;
                r = s - cl;
                cut = 1'b0;
                if (r >= 0 && r < cyc && a_cmd[r] == 2'b01) begin
                    for (int w = r + 1; w < cyc; w++) if (a_cmd[w] == 2'b10) cut = 1'b1;
                    if (!cut) infl = 1'b1;
                end
            end
            if (infl) chk(a_dqa[cyc-1], "R6", "DQM before cutting WRITE", a_dqa[cyc-1], 1);
            if (gap_en) chk(slot_st(cyc - 1, 1'b1) != 1, "R9", "read data before WRITE", 1, 0);
        end
        sd_dq_in = drv ? sd_val(cyc) : '0;

        hv = (q_head < q_n) && (q_kind[q_head] != 0);
        hw = hv && (q_kind[q_head] == 2);
        req_valid = hv;
        req_write = hw;
        if (q_head < q_n) begin
            req_bank = q_bank[q_head]; req_col = q_col[q_head];
            req_wdata = q_data[q_head]; req_mask = q_mask[q_head]; req_tag = q_tag[q_head];
        end

        trunc = 1'b0;
        for (int s = cyc + 1; s <= cyc + 4; s++) if (slot_st(s, 1'b0) == 1) trunc = 1'b1;
        ok = (!trunc || m_dqa[cyc]) && (!gap_en || slot_st(cyc, 1'b0) != 1);
        exp_ready = !hw || ok;
        nx_oe = 1'b0; nx_dqm = '0; nx_cmd = 2'b00; nx_lbl = "R2";
        if (hv && exp_ready) begin
            nx_bank = q_bank[q_head]; nx_col = q_col[q_head]; nx_tag = q_tag[q_head];
            if (hw) begin
                nx_cmd = 2'b10; nx_dqm = q_mask[q_head]; nx_data = q_data[q_head];
                nx_oe = 1'b1; nx_lbl = "R5";
            end else begin
                nx_cmd = 2'b01; nx_lbl = "R3";
            end
        end else if (hw) begin
            nx_dqm = '1; nx_lbl = "R6";
        end
        #1;
        chk(req_ready === exp_ready, "R11", "req_ready", req_ready, exp_ready);
        acc_prev = (q_head < q_n) && (!hv || exp_ready);
        cyc++;
    endtask

    task automatic run_queue();
        while (q_head < q_n && !done) step();
    endtask

    task automatic set_cfg(bit c3, bit g);
        cas3 = c3; gap_en = g; cl = c3 ? 3 : 2;
    endtask

    task automatic stream_then_write(int n_rd, logic [MW-1:0] m);
        for (int i = 0; i < n_rd; i++) push(1, BW'(i), CW'(i * 5 + 1), '0, '0);
        push(2, 2'd1, 9'h1A5, 16'hC3A0 + 16'(n_rd), m);
    endtask

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < HN; i++) begin
            a_cmd[i] = 2'b00; m_cmd[i] = 2'b00; a_dqa[i] = 1'b0; m_dqa[i] = 1'b0; m_tag[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(sd_cmd === 2'b00, "R1", "command in reset", sd_cmd, 0);
        chk(sd_dqm === '0, "R1", "dqm in reset", sd_dqm, 0);
        chk(sd_dq_oe === 1'b0, "R1", "oe in reset", sd_dq_oe, 0);
        chk(rd_valid === 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;

        // CL 2, no gap: truncation, drained write, mixed
        set_cfg(1'b0, 1'b0);
        idles(3); stream_then_write(6, 2'b00); idles(8);
        for (int i = 0; i < 3; i++) push(1, 2'd2, CW'(40 + i), '0, '0);
        idles(6); push(2, 2'd0, 9'h011, 16'h5A5A, 2'b01);
        push(1, 2'd3, 9'h022, '0, '0); push(2, 2'd3, 9'h023, 16'h1234, 2'b10); idles(8);
        run_queue();

        // CL 3, no gap
        set_cfg(1'b1, 1'b0);
        stream_then_write(5, 2'b11); idles(8);
        run_queue();

        // CL 3 with turnaround gap
        set_cfg(1'b1, 1'b1);
        stream_then_write(5, 2'b00); push(2, 2'd2, 9'h0F0, 16'hBEEF, 2'b00); idles(8);
        push(1, 2'd1, 9'h033, '0, '0); idles(1); push(2, 2'd1, 9'h034, 16'h7777, 2'b00); idles(8);
        run_queue();

        // CL 2 with turnaround gap
        set_cfg(1'b0, 1'b1);
        stream_then_write(4, 2'b00); idles(8);
        run_queue();

        // pseudo-random mixes under each setting
        lf = 16'hACE1;
        for (int ph = 0; ph < 4; ph++) begin
            set_cfg(ph[0], ph[1]);
            for (int i = 0; i < 70; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                if (lf[2:0] < 3'd2)      push(0, '0, '0, '0, '0);
                else if (lf[2:0] < 3'd6) push(1, lf[4:3], lf[13:5], '0, '0);
                else                     push(2, lf[6:5], lf[15:7], lf ^ 16'h9E37, lf[9:8]);
            end
            idles(8);
            run_queue();
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog all requirements: actual hung run, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule